// File: doc/BRIEF.md
# Multi-format serial audio port receiver

This block receives a stereo serial audio stream as a clock slave. It takes a bit clock, a frame (channel-select) clock and a serial data line, all asynchronous to the system clock. It delivers one left and one right sample per frame on 24-bit parallel outputs, together with a one-cycle strobe. The three serial inputs pass through a synchronizer into the system clock domain. The receiver then acts on the bit-clock edge that the configuration selects as its sampling edge.

Static configuration inputs set four things: the framing format (right justified, left justified, I2S or DSP), the word length, which bit-clock edge samples the data, and the frame-clock sense. In DSP framing the frame-clock sense bit instead picks where the word starts relative to the sync pulse.

The block counts bit clocks in every frame-clock half. When it sees two consecutive 16-bit halves, it switches to 16-bit words for the formats that use a level frame clock, whatever word length is programmed.

Top module: `aspr_rx`

## Requirements
- R1: With `fmt_sel`=01 (left justified), the MSB is the first bit sampled after a frame-clock change, and the word that follows is captured MSB first.
- R2: With `fmt_sel`=10 (I2S), the MSB is the second bit sampled after a frame-clock change. When the half is exactly as long as the word, the LSB is the first bit of the next half.
- R3: With `fmt_sel`=00 (right justified), the word's LSB is the last bit sampled before the frame-clock change that ends the half.
- R4: With `fmt_sel`=11 (DSP), a frame opens with a frame-clock pulse one bit long, and the left word is followed at once by the right word. When `frame_pol`=0 the MSB is one bit after the pulse bit. When `frame_pol`=1 the MSB is the pulse bit itself.
- R5: `wlen_sel` codes 00, 01, 10 and 11 select 16, 20, 24 and 24 bits. Each sample is left-aligned in the 24-bit output, and the unused LSBs are zero.
- R6: With `bclk_inv`=0, data and frame clock are sampled on the rising bit-clock edge. With `bclk_inv`=1 they are sampled on the falling edge.
- R7: In the three level-framed formats with `frame_pol`=0, the left channel is frame-clock high for left and right justified and frame-clock low for I2S. `frame_pol`=1 swaps the two levels.
- R8: After two consecutive frame-clock halves of exactly 16 bits each, the level-framed formats use 16-bit words. This holds from the next half on, regardless of `wlen_sel`, and is re-judged at every frame-clock change.
- R9: In 24-bit I2S, data narrower than 24 bits followed by zero bits in a half of at least 24 bits is delivered with its valid bits at the top of the output.
- R10: `sample_valid` pulses for exactly one cycle after each right word completes and presents that frame's left and right samples. The sample outputs never change in any other cycle.
- R11: While `rst` is high and after it is released, the sample outputs read zero and `sample_valid` is low until the first right word completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_clk | input | 1 | Serial bit clock from the transmitter |
| frame_clk | input | 1 | Channel-select level or DSP sync pulse |
| ser_data | input | 1 | Serial audio data, MSB first |
| fmt_sel | input | 2 | Framing format: 00 right just., 01 left just., 10 I2S, 11 DSP |
| wlen_sel | input | 2 | Word length: 00=16, 01=20, 1x=24 bits |
| bclk_inv | input | 1 | Sample on the falling bit-clock edge when 1 |
| frame_pol | input | 1 | Channel-level swap, or DSP start position (0 = late, 1 = on pulse) |
| left_data | output | 24 | Left sample, left-aligned |
| right_data | output | 24 | Right sample, left-aligned |
| sample_valid | output | 1 | One-cycle strobe, new sample pair |

## Verification
A wrong internal state shows within one frame. A bit counter or start index that is off by one shifts every sample by one bit position. This doubles or halves the value, or lifts one bit into the zero padding. A wrong channel level or a missed DSP pulse swaps or drops a word, so a pair arrives whose right half belongs to another frame. A stuck 16-bit detector leaves wrong-width words in every frame that follows. The bench tags each frame's left word with a unique top byte, so every such error appears as an unmatched pair or a break in the frame sequence.

// File: rtl/aspr_pkg.sv
package aspr_pkg;

    localparam int SAMPLE_W = 24;
    localparam int NB       = $clog2(SAMPLE_W + 1);
    localparam int SHORT_W  = 16;

    typedef logic [SAMPLE_W-1:0] sample_t;
    typedef logic [NB-1:0]       bitcnt_t;

    typedef enum logic [1:0] {
        FMT_RJ  = 2'b00,
        FMT_LJ  = 2'b01,
        FMT_I2S = 2'b10,
        FMT_DSP = 2'b11
    } fmt_e;

    typedef struct packed {
        fmt_e       fmt;
        logic [1:0] wlen;
        logic       sck_inv;
        logic       ws_pol;
    } cfg_t;

    // One sampled serial bit in the system clock domain
    typedef struct packed {
        logic stb;
        logic ws;
        logic sd;
    } serbit_t;

    // One completed channel word
    typedef struct packed {
        logic    emit;
        logic    right;
        sample_t data;
    } word_t;

    function automatic bitcnt_t wl_bits(logic [1:0] code);
        case (code)
            2'b00:   return bitcnt_t'(16);
            2'b01:   return bitcnt_t'(20);
            default: return bitcnt_t'(SAMPLE_W);
        endcase
    endfunction

    // Keep the low n bits of v and move them to the top of the sample
    function automatic sample_t left_align(sample_t v, bitcnt_t n);
        sample_t m;
        if (n >= bitcnt_t'(SAMPLE_W)) m = '1;
        else                          m = (sample_t'(1) << n) - sample_t'(1);
        return (v & m) << (bitcnt_t'(SAMPLE_W) - n);
    endfunction

endpackage

// File: rtl/aspr_edge_sync.sv
module aspr_edge_sync
    import aspr_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    sck,
    input  logic    ws,
    input  logic    sd,
    input  logic    sck_inv,
    output serbit_t bit_o
);
    logic [STAGES-1:0] sck_q, ws_q, sd_q;
    logic              eff, eff_d;

    always_ff @(posedge clk) begin
        if (rst) begin
            sck_q <= '0;
            ws_q  <= '0;
            sd_q  <= '0;
            eff_d <= 1'b0;
        end else begin
            sck_q <= {sck_q[STAGES-2:0], sck};
            ws_q  <= {ws_q[STAGES-2:0], ws};
            sd_q  <= {sd_q[STAGES-2:0], sd};
            eff_d <= eff;
        end
    end

    // All three inputs share the same delay, so their relative timing is kept
    assign eff       = sck_q[STAGES-1] ^ sck_inv;
    assign bit_o.stb = eff & ~eff_d;
    assign bit_o.ws  = ws_q[STAGES-1];
    assign bit_o.sd  = sd_q[STAGES-1];

    // R6: a sampling edge yields a single-cycle strobe
    p_stb_single_r6: assert property (@(posedge clk) disable iff (rst)
        bit_o.stb |=> !bit_o.stb);

endmodule

// File: rtl/aspr_frame_meter.sv
module aspr_frame_meter
    import aspr_pkg::*;
#(
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  serbit_t          bit_i,
    output logic             trans_o,
    output logic             ws_prev_o,
    output logic             rose_o,
    output logic [CNT_W-1:0] idx_o,
    output logic             force16_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;
    localparam logic [CNT_W-1:0] HALF16  = CNT_W'(SHORT_W);

    logic [CNT_W-1:0] cnt_q, prev_q;
    logic             ws_q, f16_q;

    assign trans_o   = bit_i.stb && (bit_i.ws != ws_q);
    assign rose_o    = trans_o && bit_i.ws;
    assign idx_o     = trans_o ? '0 : cnt_q;
    assign ws_prev_o = ws_q;
    assign force16_o = f16_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q  <= '0;
            prev_q <= '0;
            ws_q   <= 1'b0;
            f16_q  <= 1'b0;
        end else if (bit_i.stb) begin
            ws_q  <= bit_i.ws;
            cnt_q <= (idx_o == CNT_MAX) ? idx_o : idx_o + 1'b1;
            if (trans_o) begin
                prev_q <= cnt_q;
                f16_q  <= (cnt_q == HALF16) && (prev_q == HALF16);
            end
        end
    end

    // R8: the short-frame decision only moves at a frame-clock change
    p_f16_stable_r8: assert property (@(posedge clk) disable iff (rst)
        !trans_o |=> $stable(force16_o));

endmodule

// File: rtl/aspr_word_capture.sv
module aspr_word_capture
    import aspr_pkg::*;
#(
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  cfg_t             cfg_i,
    input  serbit_t          bit_i,
    input  logic             trans_i,
    input  logic             ws_prev_i,
    input  logic             rose_i,
    input  logic [CNT_W-1:0] idx_i,
    input  logic             force16_i,
    output word_t            word_o
);
    sample_t hist_q, acc_q, acc_nx;
    bitcnt_t n_q, n_nx, wl_eff;
    logic    active_q, right_q, pend_q;
    logic    left_lvl, start_now, start_ch;
    word_t   word_q;

    always_comb begin
        wl_eff   = force16_i ? bitcnt_t'(SHORT_W) : wl_bits(cfg_i.wlen);
        left_lvl = (cfg_i.fmt == FMT_I2S) ? cfg_i.ws_pol : ~cfg_i.ws_pol;
        acc_nx   = {acc_q[SAMPLE_W-2:0], bit_i.sd};
        n_nx     = n_q + 1'b1;
        start_ch = (cfg_i.fmt != FMT_DSP) && (bit_i.ws != left_lvl);
        case (cfg_i.fmt)
            FMT_LJ:  start_now = bit_i.stb && (idx_i == CNT_W'(0));
            FMT_I2S: start_now = bit_i.stb && (idx_i == CNT_W'(1));
            FMT_DSP: start_now = cfg_i.ws_pol ? rose_i : (bit_i.stb && pend_q);
            default: start_now = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hist_q   <= '0;
            acc_q    <= '0;
            n_q      <= '0;
            active_q <= 1'b0;
            right_q  <= 1'b0;
            pend_q   <= 1'b0;
            word_q   <= '0;
        end else begin
            word_q.emit <= 1'b0;
            if (bit_i.stb) begin
                hist_q <= {hist_q[SAMPLE_W-2:0], bit_i.sd};
                pend_q <= rose_i;
                if (cfg_i.fmt == FMT_RJ) begin
                    active_q <= 1'b0;
                    // The half just ended: its last bits sit in the history
                    if (trans_i) begin
                        word_q.emit  <= 1'b1;
                        word_q.right <= (ws_prev_i != left_lvl);
                        word_q.data  <= left_align(hist_q, wl_eff);
                    end
                end else if (start_now) begin
                    // A new word starts; flush a short word still in progress
                    if (active_q && n_q != '0) begin
                        word_q.emit  <= 1'b1;
                        word_q.right <= right_q;
                        word_q.data  <= left_align(acc_q, n_q);
                    end
                    acc_q    <= {{(SAMPLE_W-1){1'b0}}, bit_i.sd};
                    n_q      <= bitcnt_t'(1);
                    right_q  <= start_ch;
                    active_q <= 1'b1;
                end else if (active_q) begin
                    acc_q <= acc_nx;
                    if (n_nx == wl_eff) begin
                        word_q.emit  <= 1'b1;
                        word_q.right <= right_q;
                        word_q.data  <= left_align(acc_nx, n_nx);
                        n_q          <= '0;
                        if (cfg_i.fmt == FMT_DSP && !right_q) right_q  <= 1'b1;
                        else                                   active_q <= 1'b0;
                    end else begin
                        n_q <= n_nx;
                    end
                end
            end
        end
    end

    assign word_o = word_q;

    // R10: a finished word is announced for one cycle only
    p_emit_pulse_r10: assert property (@(posedge clk) disable iff (rst)
        word_q.emit |=> !word_q.emit);

    // R5: the bit count of a word in progress stays within the sample width
    p_count_bound_r5: assert property (@(posedge clk) disable iff (rst)
        active_q |-> (n_q <= bitcnt_t'(SAMPLE_W)));

endmodule

// File: rtl/aspr_rx.sv
module aspr_rx
    import aspr_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int CNT_W       = 6
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                bit_clk,
    input  logic                frame_clk,
    input  logic                ser_data,
    input  logic [1:0]          fmt_sel,
    input  logic [1:0]          wlen_sel,
    input  logic                bclk_inv,
    input  logic                frame_pol,
    output logic [SAMPLE_W-1:0] left_data,
    output logic [SAMPLE_W-1:0] right_data,
    output logic                sample_valid
);
    cfg_t             cfg;
    serbit_t          sbit;
    word_t            word;
    logic             trans, ws_prev, rose, force16;
    logic [CNT_W-1:0] idx;
    sample_t          l_hold_q, l_out_q, r_out_q;
    logic             valid_q;

    assign cfg.fmt     = fmt_e'(fmt_sel);
    assign cfg.wlen    = wlen_sel;
    assign cfg.sck_inv = bclk_inv;
    assign cfg.ws_pol  = frame_pol;

    aspr_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .sck     (bit_clk),
        .ws      (frame_clk),
        .sd      (ser_data),
        .sck_inv (cfg.sck_inv),
        .bit_o   (sbit)
    );

    aspr_frame_meter #(.CNT_W(CNT_W)) u_meter (
        .clk       (clk),
        .rst       (rst),
        .bit_i     (sbit),
        .trans_o   (trans),
        .ws_prev_o (ws_prev),
        .rose_o    (rose),
        .idx_o     (idx),
        .force16_o (force16)
    );

    aspr_word_capture #(.CNT_W(CNT_W)) u_capture (
        .clk       (clk),
        .rst       (rst),
        .cfg_i     (cfg),
        .bit_i     (sbit),
        .trans_i   (trans),
        .ws_prev_i (ws_prev),
        .rose_i    (rose),
        .idx_i     (idx),
        .force16_i (force16),
        .word_o    (word)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            l_hold_q <= '0;
            l_out_q  <= '0;
            r_out_q  <= '0;
            valid_q  <= 1'b0;
        end else begin
            valid_q <= 1'b0;
            if (word.emit) begin
                if (word.right) begin
                    l_out_q <= l_hold_q;
                    r_out_q <= word.data;
                    valid_q <= 1'b1;
                end else begin
                    l_hold_q <= word.data;
                end
            end
        end
    end

    assign left_data    = l_out_q;
    assign right_data   = r_out_q;
    assign sample_valid = valid_q;

    // R10: the strobe is one cycle wide
    p_valid_pulse_r10: assert property (@(posedge clk) disable iff (rst)
        sample_valid |=> !sample_valid);

    // R10: sample outputs move only together with the strobe
    p_out_hold_r10: assert property (@(posedge clk) disable iff (rst)
        (!$stable(left_data) || !$stable(right_data)) |-> sample_valid);

    // R5: 16-bit words leave the low byte of both outputs clear
    p_pad16_r5: assert property (@(posedge clk) disable iff (rst)
        (sample_valid && wlen_sel == 2'b00) |->
            (left_data[SAMPLE_W-SHORT_W-1:0] == '0 && right_data[SAMPLE_W-SHORT_W-1:0] == '0));

endmodule

// File: tb/aspr_rx_test.sv
`timescale 1ns/1ps
module aspr_rx_test;
    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic        rst, bit_clk, frame_clk, ser_data, bclk_inv, frame_pol;
    logic [1:0]  fmt_sel, wlen_sel;
    logic [23:0] left_data, right_data;
    logic        sample_valid;

    aspr_rx uut (
        .clk(clk), .rst(rst), .bit_clk(bit_clk), .frame_clk(frame_clk),
        .ser_data(ser_data), .fmt_sel(fmt_sel), .wlen_sel(wlen_sel),
        .bclk_inv(bclk_inv), .frame_pol(frame_pol), .left_data(left_data),
        .right_data(right_data), .sample_valid(sample_valid)
    );

    int    checks = 0, fails = 0;
    int    H = 32, FL = 64, W_exp = 16, D = 16, nframes = 0;
    int    lastk = -1, matched = 0, cycles = 0;
    logic  prev_valid = 1'b0;
    string tag = "R1";

    function automatic logic [23:0] lw(int k);
        return {8'(8'h10 + k), 16'(k * 16'h03b7 ^ 16'hc3a5) | 16'h8000};
    endfunction
    function automatic logic [23:0] rw(int k);
        return {8'(8'h80 + k), 16'(k * 16'h01d9 ^ 16'h5a3c) | 16'h8000};
    endfunction
    function automatic logic [23:0] top_mask(int n);
        return ~24'h0 << (24 - n);
    endfunction

    // Serial data at bit position p of the stream, built from R1-style placement rules
    function automatic logic sd_at(int p);
        logic r;
        int   k;
        r = 1'b0;
        k = p / FL;
        for (int kk = k - 1; kk <= k; kk++) begin
            if (kk >= 0) begin
                for (int ch = 0; ch < 2; ch++) begin
                    logic [23:0] w;
                    int s;
                    w = (ch != 0) ? rw(kk) : lw(kk);
                    if (fmt_sel == 2'b11)      s = kk * FL + (frame_pol ? 0 : 1) + ch * W_exp;
                    else if (fmt_sel == 2'b01) s = kk * FL + ch * H;
                    else if (fmt_sel == 2'b10) s = kk * FL + ch * H + 1;
                    else                       s = kk * FL + ch * H + (H - W_exp);
                    if (p >= s && p < s + D) r = w[23 - (p - s)];
                end
            end
        end
        return r;
    endfunction

    function automatic logic ws_at(int p);
        int   pos;
        logic lvl;
        pos = p % FL;
        if (fmt_sel == 2'b11) return (pos == 0);
        lvl = (fmt_sel == 2'b10) ? frame_pol : ~frame_pol;   // R7 left level
        return (pos < H) ? lvl : ~lvl;
    endfunction

    // Monitor: every valid pair whose left word is a known frame must carry that frame's right word
    always @(negedge clk) begin
        int k;
        cycles++;
        if (!rst) begin
            if (sample_valid && prev_valid) begin
                checks++; fails++;
                $display("FAIL R10 strobe width: actual >1 cycle expected 1");
            end
            if (sample_valid) begin
                k = -1;
                for (int i = 0; i < nframes; i++)
                    if (left_data == (lw(i) & top_mask(D))) k = i;
                if (k >= 0) begin
                    checks++;
                    // R5 R6 R7 R10: width, sampling edge, channel order and pairing
                    if (right_data !== (rw(k) & top_mask(D)) || (lastk >= 0 && k != lastk + 1)) begin
                        fails++;
                        $display("FAIL %s fmt=%0d wl=%0d inv=%0d pol=%0d frame %0d after %0d: actual %h/%h expected %h/%h",
                                 tag, fmt_sel, wlen_sel, bclk_inv, frame_pol, k, lastk,
                                 left_data, right_data, lw(k) & top_mask(D), rw(k) & top_mask(D));
                    end
                    lastk = k;
                    matched++;
                end
            end
        end
        prev_valid = sample_valid;
    end

    task automatic run(input int f, input int wl, input int inv, input int pol,
                       input int h, input int nf, input bit narrow, input string tg);
        rst = 1'b1;
        fmt_sel = 2'(f); wlen_sel = 2'(wl); bclk_inv = inv[0]; frame_pol = pol[0];
        bit_clk = inv[0]; frame_clk = 1'b0; ser_data = 1'b0;
        H = h;
        W_exp = (h == 16 && f != 3) ? 16 : (wl == 0 ? 16 : (wl == 1 ? 20 : 24));
        D = narrow ? 18 : W_exp;
        FL = (f == 3) ? 2 * W_exp + 8 : 2 * h;
        nframes = nf; tag = tg;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        lastk = -1; matched = 0;
        for (int p = 0; p < nf * FL; p++) begin
            @(negedge clk); bit_clk = inv[0]; frame_clk = ws_at(p); ser_data = sd_at(p);
            @(negedge clk);
            @(negedge clk); bit_clk = ~inv[0];
            @(negedge clk);
        end
        repeat (30) @(negedge clk);
        checks++;
        if (matched < 3) begin
            fails++;
            $display("FAIL %s fmt=%0d wl=%0d inv=%0d pol=%0d: actual %0d good frames expected >=3",
                     tg, f, wl, inv, pol, matched);
        end
    endtask

    function automatic string fmt_tag(int f);
        case (f)
            0: return "R3";
            1: return "R1";
            2: return "R2";
            default: return "R4";
        endcase
    endfunction

    initial begin
        rst = 1'b1; bit_clk = 1'b0; frame_clk = 1'b0; ser_data = 1'b0;
        fmt_sel = 2'b01; wlen_sel = 2'b00; bclk_inv = 1'b0; frame_pol = 1'b0;
        repeat (5) @(negedge clk);
        // R11: reset state
        checks++;
        if (left_data !== 24'h0 || right_data !== 24'h0 || sample_valid !== 1'b0) begin
            fails++;
            $display("FAIL R11 reset: actual %h/%h/%b expected 0/0/0", left_data, right_data, sample_valid);
        end
        rst = 1'b0;
        repeat (3) @(negedge clk);
        checks++;
        if (left_data !== 24'h0 || right_data !== 24'h0 || sample_valid !== 1'b0) begin
            fails++;
            $display("FAIL R11 idle after reset: actual %h/%h/%b expected 0/0/0", left_data, right_data, sample_valid);
        end
        // Sweep every format, word length, edge and polarity (R1 R2 R3 R4 R5 R6 R7)
        for (int f = 0; f < 4; f++)
            for (int wl = 0; wl < 4; wl++)
                for (int inv = 0; inv < 2; inv++)
                    for (int pol = 0; pol < 2; pol++)
                        run(f, wl, inv, pol, 32, 5,
                            (f == 2 && wl >= 2 && inv == 1), // R9 narrow data in 24-bit I2S
                            (f == 2 && wl >= 2 && inv == 1) ? "R9" : fmt_tag(f));
        // R8: 16+16 bit frames force 16-bit words despite a 24-bit setting
        for (int f = 0; f < 3; f++) run(f, 2, 0, 0, 16, 7, 1'b0, "R8");
        run(1, 3, 1, 1, 16, 7, 1'b0, "R8");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        wait (cycles > 190000);
        fails++; checks++;
        $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule